// File: doc/BRIEF.md
# CAN Error Status and Interrupt Unit

This block is the error-bookkeeping part of a CAN controller. It does not detect bit-level faults on the bus. Instead it receives abstract event pulses from the protocol engine: transmit error, receive error, transmit success and receive success, plus a bus-error report carrying a 3-bit cause code. From these it maintains an 8-bit transmit error count (TEC) and an 8-bit receive error count (REC). It derives three severity flags from the counts: warning, error-passive and bus-off. It also keeps a last-error-code field that software can preset to a marker value, so that it can later tell whether the bus reported anything since.

All state is gathered into one 32-bit error status word. A main status word carries a sticky error interrupt flag. An interrupt enable word holds a global enable and four per-condition enables. Software writes through a simple select/data port and reads the three words directly. The interrupt flag is cleared by writing one to it.

Bus-off is left in one of two ways. Software can request re-initialisation, which clears both counters at any time. Alternatively, when automatic recovery is enabled, a recovery-sequence pulse from the protocol engine ends bus-off.

Top module: `can_err_status`

## Requirements
- R1: After reset the error status word, the main status word, the interrupt enable word and the interrupt output are all zero.
- R2: Each transmit error pulse adds 8 to TEC (error status bits 23:16). Each receive error pulse adds 1 to REC (bits 31:24). REC saturates at 255.
- R3: A success pulse lowers the matching counter by 1 and never takes it below 0. An error pulse and a success pulse for the same counter in the same cycle apply only the error.
- R4: Warning (bit 0) is set while either counter is at 96 or more. Error-passive (bit 1) is set while either counter is at 128 or more. Bus-off implies error-passive, and error-passive implies warning.
- R5: A transmit error that would carry TEC above 255 sets bus-off (bit 2) and holds TEC at 255. While bus-off is set, all error and success pulses are ignored.
- R6: A re-initialisation request clears both counters and bus-off in any state. A recovery-sequence pulse clears them only while bus-off is set and automatic recovery is enabled; otherwise it is ignored.
- R7: A bus-error report with a code from 0 to 6 loads that code into the last-error field (bits 6:4). The code meanings are: 0 none, 1 stuff, 2 form, 3 acknowledge, 4 recessive bit, 5 dominant bit, 6 CRC. A report with code 7 is ignored. A report and a software write of the field in the same cycle leave the reported code.
- R8: A write with select 0 loads data bits 6:4 into the last-error field. All other error status bits are unaffected by the write.
- R9: A write with select 2 loads the interrupt enables, and only these bits are writable: 15 global, 11 last-error, 10 bus-off, 9 passive, 8 warning. All other bits read 0.
- R10: The interrupt flag (main status bit 2, also driven on the interrupt output) sets when the global enable and a condition's own enable are both set and that condition occurs. The conditions are: warning, passive or bus-off going from 0 to 1, or a report with a code from 1 to 6. Once set, the flag stays set until it is cleared.
- R11: A write with select 1 and data bit 2 set clears the interrupt flag. Such a write with bit 2 clear has no effect. A new condition in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_evt | input | 1 | Transmit error event pulse |
| rx_err_evt | input | 1 | Receive error event pulse |
| tx_ok_evt | input | 1 | Transmit success event pulse |
| rx_ok_evt | input | 1 | Receive success event pulse |
| bus_err_vld | input | 1 | Bus-error report strobe |
| bus_err_code | input | 3 | Bus-error cause code |
| auto_recover_en | input | 1 | Automatic bus-off recovery enable |
| recover_seq | input | 1 | Recovery-sequence-complete pulse |
| reinit_req | input | 1 | Software re-initialisation request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 error status, 1 main status, 2 interrupt enable |
| wr_data | input | 32 | Write data |
| err_status_o | output | 32 | Error status word |
| main_status_o | output | 32 | Main status word (bit 2 interrupt flag) |
| irq_enable_o | output | 32 | Interrupt enable word |
| err_irq_o | output | 1 | Error interrupt output |

## Verification
Properties checked on every cycle:
- The severity flags stay ordered.
- Each admitted transmit error moves TEC by exactly one step.
- A counter at zero does not wrap on a success pulse.
- Bus-off freezes both counters.
- The last-error field holds when nothing touches it.
- The interrupt flag neither sets without the global enable nor drops without a clear.

Only the bench's scenarios can show the rest:
- The exact threshold crossings at 96 and 128.
- The bus-off point on the 32nd transmit error.
- REC saturation at 255.
- The two recovery paths.
- The full matrix of enable combinations against each condition source.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int CNT_W     = 8;
  localparam int LEC_W     = 3;
  localparam int REG_W     = 32;

  localparam int ST_REC_LSB  = 24;
  localparam int ST_TEC_LSB  = 16;
  localparam int ST_LEC_LSB  = 4;
  localparam int ST_BOFF     = 2;
  localparam int ST_PASSIVE  = 1;
  localparam int ST_WARN     = 0;

  localparam int MS_IRQ      = 2;

  localparam int IE_GLOBAL   = 15;
  localparam int IE_LEC      = 11;
  localparam int IE_BOFF     = 10;
  localparam int IE_PASSIVE  = 9;
  localparam int IE_WARN     = 8;

  typedef enum logic [LEC_W-1:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BIT1  = 3'd4,
    LEC_BIT0  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_MARK  = 3'd7
  } lec_e;

  typedef enum logic [1:0] {
    SEL_ERRSTAT  = 2'd0,
    SEL_MAINSTAT = 2'd1,
    SEL_IRQEN    = 2'd2,
    SEL_NONE     = 2'd3
  } regsel_e;
endpackage

// File: rtl/can_err_counters.sv
module can_err_counters #(
  parameter int CNT_W         = 8,
  parameter int TX_ERR_STEP   = 8,
  parameter int RX_ERR_STEP   = 1,
  parameter int WARN_LEVEL    = 96,
  parameter int PASSIVE_LEVEL = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             rx_err,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             auto_recover,
  input  logic             recover_seq,
  input  logic             reinit,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             warn_o,
  output logic             passive_o,
  output logic             bus_off_o,
  output logic             warn_rise_o,
  output logic             passive_rise_o,
  output logic             bus_off_rise_o
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] CNT_CEIL = {1'b0, {CNT_W{1'b1}}};
  localparam logic [SUM_W-1:0] TX_STEP  = SUM_W'(TX_ERR_STEP);
  localparam logic [SUM_W-1:0] RX_STEP  = SUM_W'(RX_ERR_STEP);
  localparam logic [CNT_W-1:0] WARN_TH  = CNT_W'(WARN_LEVEL);
  localparam logic [CNT_W-1:0] PASS_TH  = CNT_W'(PASSIVE_LEVEL);

  logic [CNT_W-1:0] tec_q, tec_d, rec_q, rec_d;
  logic             boff_q, boff_d;
  logic             warn_q, warn_d, pass_q, pass_d;
  logic [SUM_W-1:0] tx_sum, rx_sum;
  logic             recover_go, cnt_en;

  always_comb begin
    tx_sum     = {1'b0, tec_q} + TX_STEP;
    rx_sum     = {1'b0, rec_q} + RX_STEP;
    recover_go = reinit | (auto_recover & recover_seq & boff_q);
    cnt_en     = tx_err | rx_err | tx_ok | rx_ok | recover_go;
    tec_d      = tec_q;
    rec_d      = rec_q;
    boff_d     = boff_q;
    if (recover_go) begin
      tec_d  = '0;
      rec_d  = '0;
      boff_d = 1'b0;
    end else if (!boff_q) begin
      if (tx_err) begin
        if (tx_sum > CNT_CEIL) begin
          tec_d  = '1;
          boff_d = 1'b1;
        end else begin
          tec_d = tx_sum[CNT_W-1:0];
        end
      end else if (tx_ok && (tec_q != '0)) begin
        tec_d = tec_q - 1'b1;
      end
      if (rx_err) begin
        rec_d = (rx_sum > CNT_CEIL) ? '1 : rx_sum[CNT_W-1:0];
      end else if (rx_ok && (rec_q != '0)) begin
        rec_d = rec_q - 1'b1;
      end
    end
    warn_d = (tec_d >= WARN_TH) | (rec_d >= WARN_TH);
    pass_d = (tec_d >= PASS_TH) | (rec_d >= PASS_TH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q  <= '0;
      rec_q  <= '0;
      boff_q <= 1'b0;
      warn_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (cnt_en) begin
      tec_q  <= tec_d;
      rec_q  <= rec_d;
      boff_q <= boff_d;
      warn_q <= warn_d;
      pass_q <= pass_d;
    end
  end

  assign tec_o          = tec_q;
  assign rec_o          = rec_q;
  assign warn_o         = warn_q;
  assign passive_o      = pass_q;
  assign bus_off_o      = boff_q;
  assign warn_rise_o    = cnt_en & warn_d & ~warn_q;
  assign passive_rise_o = cnt_en & pass_d & ~pass_q;
  assign bus_off_rise_o = cnt_en & boff_d & ~boff_q;

  assert_boff_implies_passive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    boff_q |-> pass_q);
  assert_passive_implies_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> warn_q);
  assert_tx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !boff_q && !reinit && (tx_sum <= CNT_CEIL))
      |=> (tec_q == $past(tec_q) + CNT_W'(TX_ERR_STEP)));
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok && !tx_err && !boff_q && (tec_q == '0)) |=> (tec_q == '0));
  assert_boff_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (boff_q && !reinit && !(auto_recover && recover_seq))
      |=> (boff_q && $stable(tec_q) && $stable(rec_q)));
endmodule

// File: rtl/can_err_lec.sv
module can_err_lec #(
  parameter int LEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_vld,
  input  logic [LEC_W-1:0] hw_code,
  input  logic             sw_wr,
  input  logic [LEC_W-1:0] sw_code,
  output logic [LEC_W-1:0] lec_o,
  output logic             hw_err_o
);
  localparam logic [LEC_W-1:0] CODE_MARK = '1;
  localparam logic [LEC_W-1:0] CODE_NONE = '0;

  logic [LEC_W-1:0] lec_q, lec_d;
  logic             hw_take, lec_en;

  always_comb begin
    hw_take = hw_vld & (hw_code != CODE_MARK);
    lec_en  = hw_take | sw_wr;
    lec_d   = hw_take ? hw_code : sw_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lec_q <= '0;
    end else if (lec_en) begin
      lec_q <= lec_d;
    end
  end

  assign lec_o    = lec_q;
  assign hw_err_o = hw_take & (hw_code != CODE_NONE);

  assert_lec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_vld && !sw_wr) |=> $stable(lec_q));
  assert_hw_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_vld && (hw_code != CODE_MARK)) |=> (lec_q == $past(hw_code)));
endmodule

// File: rtl/can_err_irq.sv
module can_err_irq #(
  parameter int REG_W      = 32,
  parameter int IE_GLOBAL  = 15,
  parameter int IE_LEC     = 11,
  parameter int IE_BOFF    = 10,
  parameter int IE_PASSIVE = 9,
  parameter int IE_WARN    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ie_wr,
  input  logic [REG_W-1:0] ie_wdata,
  input  logic             irq_clr,
  input  logic             warn_rise,
  input  logic             passive_rise,
  input  logic             bus_off_rise,
  input  logic             lec_err,
  output logic [REG_W-1:0] ie_o,
  output logic             irq_o
);
  localparam logic [REG_W-1:0] IE_MASK =
      (REG_W'(1) << IE_GLOBAL) | (REG_W'(1) << IE_LEC) | (REG_W'(1) << IE_BOFF) |
      (REG_W'(1) << IE_PASSIVE) | (REG_W'(1) << IE_WARN);

  logic [REG_W-1:0] ie_q;
  logic             irq_q, irq_d, irq_set, irq_en, cond_hit;

  always_comb begin
    cond_hit = (warn_rise    & ie_q[IE_WARN])
             | (passive_rise & ie_q[IE_PASSIVE])
             | (bus_off_rise & ie_q[IE_BOFF])
             | (lec_err      & ie_q[IE_LEC]);
    irq_set  = ie_q[IE_GLOBAL] & cond_hit;
    irq_en   = irq_set | irq_clr;
    irq_d    = irq_set | (irq_q & ~irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
    end else if (ie_wr) begin
      ie_q <= ie_wdata & IE_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end

  assign ie_o  = ie_q;
  assign irq_o = irq_q;

  assert_global_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q[IE_GLOBAL] && !irq_q) |=> !irq_q);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && irq_clr && !cond_hit) |=> !irq_q);
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q[IE_GLOBAL] && cond_hit) |=> irq_q);
endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_err_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_err_evt,
  input  logic                 rx_err_evt,
  input  logic                 tx_ok_evt,
  input  logic                 rx_ok_evt,
  input  logic                 bus_err_vld,
  input  logic [LEC_W-1:0]     bus_err_code,
  input  logic                 auto_recover_en,
  input  logic                 recover_seq,
  input  logic                 reinit_req,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     err_status_o,
  output logic [REG_W-1:0]     main_status_o,
  output logic [REG_W-1:0]     irq_enable_o,
  output logic                 err_irq_o
);
  regsel_e          sel;
  logic             esr_wr, ie_wr, irq_clr;
  logic [CNT_W-1:0] tec, rec;
  logic             warn, passive, bus_off;
  logic             warn_rise, passive_rise, bus_off_rise;
  logic [LEC_W-1:0] lec;
  logic             lec_err, irq;

  always_comb begin
    sel     = regsel_e'(wr_sel);
    esr_wr  = wr_en & (sel == SEL_ERRSTAT);
    ie_wr   = wr_en & (sel == SEL_IRQEN);
    irq_clr = wr_en & (sel == SEL_MAINSTAT) & wr_data[MS_IRQ];
  end

  can_err_counters #(
    .CNT_W        (CNT_W),
    .TX_ERR_STEP  (8),
    .RX_ERR_STEP  (1),
    .WARN_LEVEL   (96),
    .PASSIVE_LEVEL(128)
  ) u_counters (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_err         (tx_err_evt),
    .rx_err         (rx_err_evt),
    .tx_ok          (tx_ok_evt),
    .rx_ok          (rx_ok_evt),
    .auto_recover   (auto_recover_en),
    .recover_seq    (recover_seq),
    .reinit         (reinit_req),
    .tec_o          (tec),
    .rec_o          (rec),
    .warn_o         (warn),
    .passive_o      (passive),
    .bus_off_o      (bus_off),
    .warn_rise_o    (warn_rise),
    .passive_rise_o (passive_rise),
    .bus_off_rise_o (bus_off_rise)
  );

  can_err_lec #(
    .LEC_W(LEC_W)
  ) u_lec (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_vld   (bus_err_vld),
    .hw_code  (bus_err_code),
    .sw_wr    (esr_wr),
    .sw_code  (wr_data[ST_LEC_LSB +: LEC_W]),
    .lec_o    (lec),
    .hw_err_o (lec_err)
  );

  can_err_irq #(
    .REG_W     (REG_W),
    .IE_GLOBAL (IE_GLOBAL),
    .IE_LEC    (IE_LEC),
    .IE_BOFF   (IE_BOFF),
    .IE_PASSIVE(IE_PASSIVE),
    .IE_WARN   (IE_WARN)
  ) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ie_wr        (ie_wr),
    .ie_wdata     (wr_data),
    .irq_clr      (irq_clr),
    .warn_rise    (warn_rise),
    .passive_rise (passive_rise),
    .bus_off_rise (bus_off_rise),
    .lec_err      (lec_err),
    .ie_o         (irq_enable_o),
    .irq_o        (irq)
  );

  always_comb begin
    err_status_o                          = '0;
    err_status_o[ST_REC_LSB +: CNT_W]     = rec;
    err_status_o[ST_TEC_LSB +: CNT_W]     = tec;
    err_status_o[ST_LEC_LSB +: LEC_W]     = lec;
    err_status_o[ST_BOFF]                 = bus_off;
    err_status_o[ST_PASSIVE]              = passive;
    err_status_o[ST_WARN]                 = warn;
    main_status_o                         = '0;
    main_status_o[MS_IRQ]                 = irq;
  end

  assign err_irq_o = irq;
endmodule

// File: tb/can_err_status_tb.sv
module can_err_status_tb;
  localparam int CLK_P = 10;

  logic        clk, rst_n;
  logic        tx_err_evt, rx_err_evt, tx_ok_evt, rx_ok_evt;
  logic        bus_err_vld;
  logic [2:0]  bus_err_code;
  logic        auto_recover_en, recover_seq, reinit_req;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] err_status_o, main_status_o, irq_enable_o;
  logic        err_irq_o;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  can_err_status u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_err_evt(tx_err_evt), .rx_err_evt(rx_err_evt),
    .tx_ok_evt(tx_ok_evt), .rx_ok_evt(rx_ok_evt),
    .bus_err_vld(bus_err_vld), .bus_err_code(bus_err_code),
    .auto_recover_en(auto_recover_en), .recover_seq(recover_seq),
    .reinit_req(reinit_req),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .err_status_o(err_status_o), .main_status_o(main_status_o),
    .irq_enable_o(irq_enable_o), .err_irq_o(err_irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mk_esr(input int r, input int t, input int l, input bit bo);
    logic [31:0] v;
    v        = '0;
    v[31:24] = r[7:0];
    v[23:16] = t[7:0];
    v[6:4]   = l[2:0];
    v[2]     = bo;
    v[1]     = (t >= 128) || (r >= 128);
    v[0]     = (t >= 96) || (r >= 96);
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    tx_err_evt = 0; rx_err_evt = 0; tx_ok_evt = 0; rx_ok_evt = 0;
    bus_err_vld = 0; bus_err_code = 0; recover_seq = 0; reinit_req = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
  endtask

  task automatic put(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit exp_irq;
    int exp_v;
    rst_n = 0; auto_recover_en = 0;
    tx_err_evt = 0; rx_err_evt = 0; tx_ok_evt = 0; rx_ok_evt = 0;
    bus_err_vld = 0; bus_err_code = 0; recover_seq = 0; reinit_req = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 esr", err_status_o, 32'h0);
    chk("R1 msr", main_status_o, 32'h0);
    chk("R1 ier", irq_enable_o, 32'h0);
    chk("R1 irq", {31'b0, err_irq_o}, 32'h0);

    // R9 only enable bits writable
    put(2'd2, 32'hFFFF_FFFF); tick();
    chk("R9 ier mask", irq_enable_o, 32'h0000_8F00);
    put(2'd2, 32'h0); tick();
    chk("R9 ier clear", irq_enable_o, 32'h0);

    // R2 R4 R5 transmit sweep to bus-off
    for (int k = 1; k <= 32; k++) begin
      tx_err_evt = 1; tick();
      exp_v = (8 * k > 255) ? 255 : 8 * k;
      chk("R2 R4 R5 tx sweep", err_status_o, mk_esr(0, exp_v, 0, k == 32));
    end
    chk("R10 gated irq", main_status_o, 32'h0);

    // R5 frozen while bus-off
    tx_err_evt = 1; rx_err_evt = 1; tick();
    tx_ok_evt = 1; rx_ok_evt = 1; tick();
    chk("R5 freeze", err_status_o, mk_esr(0, 255, 0, 1));

    // R6 recovery paths
    recover_seq = 1; tick();
    chk("R6 no auto", err_status_o, mk_esr(0, 255, 0, 1));
    auto_recover_en = 1; recover_seq = 1; tick();
    chk("R6 auto", err_status_o, mk_esr(0, 0, 0, 0));
    auto_recover_en = 0;

    // R2 R4 receive sweep with saturation
    for (int k = 1; k <= 260; k++) begin
      rx_err_evt = 1; tick();
      exp_v = (k > 255) ? 255 : k;
      chk("R2 R4 rx sweep", err_status_o, mk_esr(exp_v, 0, 0, 0));
    end

    // R3 decrement to zero without wrap
    for (int j = 1; j <= 256; j++) begin
      rx_ok_evt = 1; tick();
      exp_v = (255 - j < 0) ? 0 : 255 - j;
      chk("R3 rx down", err_status_o, mk_esr(exp_v, 0, 0, 0));
    end
    tx_ok_evt = 1; tick();
    chk("R3 tec floor", err_status_o, mk_esr(0, 0, 0, 0));
    tx_err_evt = 1; tx_ok_evt = 1; tick();
    chk("R3 error wins", err_status_o, mk_esr(0, 8, 0, 0));
    tx_ok_evt = 1; tick();
    chk("R3 tx down", err_status_o, mk_esr(0, 7, 0, 0));
    rx_err_evt = 1; tick();
    reinit_req = 1; tick();
    chk("R6 reinit", err_status_o, mk_esr(0, 0, 0, 0));

    // R7 codes
    for (int c = 0; c <= 6; c++) begin
      bus_err_vld = 1; bus_err_code = c[2:0]; tick();
      chk("R7 code load", err_status_o, mk_esr(0, 0, c, 0));
    end
    put(2'd0, 32'hFFFF_FFFF); tick();
    chk("R8 sw mark", err_status_o, mk_esr(0, 0, 7, 0));
    bus_err_vld = 1; bus_err_code = 3'd7; tick();
    chk("R7 code7 ignored", err_status_o, mk_esr(0, 0, 7, 0));
    bus_err_vld = 1; bus_err_code = 3'd3; put(2'd0, 32'h0000_0050); tick();
    chk("R7 hw wins", err_status_o, mk_esr(0, 0, 3, 0));

    // R10 R11 enable matrix against each condition source
    for (int m = 0; m < 32; m++) begin
      for (int s = 0; s < 4; s++) begin
        reinit_req = 1; put(2'd1, 32'h4); tick();
        put(2'd2, (32'(m[4]) << 15) | (32'(m[3:0]) << 8)); tick();
        case (s)
          0: begin bus_err_vld = 1; bus_err_code = 3'd1; tick(); end
          1: for (int k = 0; k < 12; k++) begin tx_err_evt = 1; tick(); end
          2: for (int k = 0; k < 16; k++) begin tx_err_evt = 1; tick(); end
          default: for (int k = 0; k < 32; k++) begin tx_err_evt = 1; tick(); end
        endcase
        exp_irq = m[4] && ((m[3] && s == 0) || (m[0] && s >= 1) ||
                           (m[1] && s >= 2) || (m[2] && s == 3));
        chk("R10 matrix msr", main_status_o, exp_irq ? 32'h4 : 32'h0);
        chk("R10 matrix pin", {31'b0, err_irq_o}, {31'b0, exp_irq});
        if (exp_irq) begin
          reinit_req = 1; put(2'd1, 32'hFFFF_FFFB); tick();
          chk("R10 R11 sticky", main_status_o, 32'h4);
          put(2'd1, 32'h4); tick();
          chk("R11 w1c", main_status_o, 32'h0);
        end
      end
    end

    // R11 set beats clear
    reinit_req = 1; put(2'd1, 32'h4); tick();
    put(2'd2, 32'h0000_8800); tick();
    bus_err_vld = 1; bus_err_code = 3'd2; put(2'd1, 32'h4); tick();
    chk("R11 set wins", main_status_o, 32'h4);
    put(2'd1, 32'h4); tick();
    chk("R11 clear", {31'b0, err_irq_o}, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule